// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block models a small nonvolatile memory that a host reaches over a four-wire Microwire-style serial link: chip select, serial clock, serial data in and serial data out. The host selects the block, clocks in a frame, and the block answers on its data output. A frame is a start bit, a two-bit opcode and a seven-bit address. The storage is 128 bytes held in registers. Programming is modelled as a self-timed busy period whose length is a parameter, counted in system clocks.

The serial pins are oversampled in a single system clock domain. A host reads single bytes or streams consecutive bytes. It can write a page of up to 16 bytes, erase one byte, clear the whole array or fill it with one value, and lock or unlock programming. No program operation starts until chip select drops. During programming the data output reports busy, and once programming ends it reports ready until the host clocks in the next start bit.

The control state machine has these states: `ST_IDLE` (hunting for a start bit), `ST_OPC` (two opcode bits), `ST_ADDR` (seven address bits), `ST_READ` (streaming out), `ST_WDATA` (collecting page bytes), `ST_FILLDATA` (collecting the fill byte), `ST_HOLD` (an erase-type command complete, waiting for deselect), `ST_SKIP` (lock or unlock done, ignoring clocks) and `ST_BUSY` (self-timed programming). The transitions are:
- `ST_IDLE` goes to `ST_OPC` on a 1 sampled while selected.
- `ST_OPC` goes to `ST_ADDR` after two bits.
- After the seventh address bit, `ST_ADDR` goes to `ST_READ`, `ST_WDATA`, `ST_FILLDATA`, `ST_HOLD` or `ST_SKIP` according to the command.
- `ST_FILLDATA` goes to `ST_HOLD` after eight data bits.
- Every state except `ST_BUSY` leaves on deselect. It goes to `ST_BUSY` when an operation is pending and programming is unlocked, and to `ST_IDLE` otherwise.
- `ST_BUSY` returns to `ST_IDLE` when the timer expires.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the data output is not driven, programming is locked, and every location reads 0xFF.
- R2: While selected, 0 bits are skipped until a 1 arrives as the start bit. The next two bits form the opcode and the next seven form the address, MSB first, all sampled on rising serial clock edges.
- R3: Opcode 10 reads. After the last address bit the output is driven with a 0 dummy bit, then the byte MSB first, one bit per rising serial clock edge.
- R4: If clocking continues after a read byte, the bytes at following addresses stream out with no further dummy bit, wrapping from address 127 to 0.
- R5: Opcode 00 with address bits [6:5]=11 unlocks programming and 00 locks it. While locked, write, erase, clear-all and fill-all leave the array unchanged and start no busy period, but reads still work.
- R6: Opcode 01 writes. Data bytes follow the address directly. Each further byte goes to the next address, and only the low 4 address bits increment, so the address wraps within its 16-byte page. Only complete bytes are stored, and only after deselect.
- R7: Opcode 11 erases the addressed location to 0xFF when deselected.
- R8: Opcode 00 with address bits [6:5]=10 sets every location to 0xFF. With 01 it takes one data byte and writes it to every location.
- R9: A program operation starts when chip select falls and lasts BUSY_CYC system clocks. During it, whenever the block is selected, the output is driven 0.
- R10: After programming the output is driven 1 whenever the block is selected. This continues until a start bit is clocked in, after which the output is released.
- R11: Frames clocked in during a busy period are ignored, including lock and unlock.
- R12: The output is not driven while deselected. Deselecting in mid-frame aborts it, and an incomplete write stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data or status to the host |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
A corrupted frame counter or opcode register shows up within one byte time as a shifted or wrong read byte, or as a missing dummy zero right after the address. A wrong lock latch or pending-operation register shows only after the next deselect: it appears as a busy indication that should not exist, or as an array left unchanged when it should have changed, and a read-back reveals it a few hundred clocks later. A stuck ready flag shows at once the next time the block is selected after a start bit, because the output stays driven high.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_READ,
        ST_WDATA,
        ST_FILLDATA,
        ST_HOLD,
        ST_SKIP,
        ST_BUSY
    } smem_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRITE,
        OP_ERASE,
        OP_CLEAR_ALL,
        OP_FILL_ALL
    } smem_op_e;

    // opcode field values (decoded by the host protocol)
    localparam logic [1:0] CODE_EXT   = 2'b00;
    localparam logic [1:0] CODE_WRITE = 2'b01;
    localparam logic [1:0] CODE_READ  = 2'b10;
    localparam logic [1:0] CODE_ERASE = 2'b11;

    // sub-command values in the top two address bits of CODE_EXT
    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_CLEAR  = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    genvar g;
    for (g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], async_i[g]};
            end
        end
        assign sync_o[g] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/smem_busy_timer.sv
module smem_busy_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i && (cnt_q == '0)) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));

endmodule

// File: rtl/smem_array.sv
module smem_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    rd_addr_i,
    output logic [DATA_W-1:0]                    rd_data_o,
    input  logic                                 page_we_i,
    input  logic [ADDR_W-PAGE_W-1:0]             page_base_i,
    input  logic [(1<<PAGE_W)-1:0]               page_mask_i,
    input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0]   page_data_i,
    input  logic                                 erase_i,
    input  logic [ADDR_W-1:0]                    erase_addr_i,
    input  logic                                 fill_i,
    input  logic [DATA_W-1:0]                    fill_data_i
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] cells;

    genvar g;
    for (g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] LOC = ADDR_W'(g);
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '1;
            end else if (fill_i) begin
                q <= fill_data_i;
            end else if (erase_i && (erase_addr_i == LOC)) begin
                q <= '1;
            end else if (page_we_i && (page_base_i == LOC[ADDR_W-1:PAGE_W])
                         && page_mask_i[LOC[PAGE_W-1:0]]) begin
                q <= page_data_i[LOC[PAGE_W-1:0]];
            end
        end
        assign cells[g] = q;
    end

    assign rd_data_o = cells[rd_addr_i];

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import smem_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYC    = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);

    localparam int PAGES  = 1 << PAGE_W;
    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam int MAXB   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_W  = $clog2(MAXB + 1);

    // ---------------- pin synchronisation ----------------
    logic [2:0] sync_v;
    logic       cs_s, sk_s, di_s, sk_q, sk_rise;

    smem_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sk_i, di_i}),
        .sync_o  (sync_v)
    );

    assign cs_s = sync_v[2];
    assign sk_s = sync_v[1];
    assign di_s = sync_v[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk_s;
    end

    assign sk_rise = sk_s & ~sk_q & cs_s;

    // ---------------- state and datapath registers ----------------
    smem_state_e                    st_q, st_d;
    smem_op_e                       pend_q;
    logic [1:0]                     opc_q;
    logic [ADDR_W-1:0]              addr_q;
    logic [CNT_W-1:0]               bit_cnt;
    logic [DATA_W-1:0]              shreg;
    logic                           do_q;
    logic                           wen_q;
    logic                           rdy_q;
    logic [PAGES-1:0][DATA_W-1:0]   pbuf_q;
    logic [PAGES-1:0]               pmask_q;
    logic [PAGE_W-1:0]              ptr_q;
    logic [BASE_W-1:0]              base_q;
    logic [DATA_W-1:0]              fill_q;

    logic              tmr_busy, tmr_done, launch;
    logic [ADDR_W-1:0] full_addr, rd_addr;
    logic [DATA_W-1:0] rd_data, next_byte;
    logic [1:0]        ext_sel;
    logic              addr_last, data_last;

    assign full_addr = {addr_q[ADDR_W-2:0], di_s};
    assign ext_sel   = full_addr[ADDR_W-1 -: 2];
    assign next_byte = {shreg[DATA_W-2:0], di_s};
    assign addr_last = (bit_cnt == CNT_W'(ADDR_W - 1));
    assign data_last = (bit_cnt == CNT_W'(DATA_W - 1));
    assign launch    = (st_q != ST_BUSY) && !cs_s && wen_q && (pend_q != OP_NONE);
    assign rd_addr   = (st_q == ST_ADDR) ? full_addr : addr_q + 1'b1;

    // ---------------- submodules ----------------
    smem_busy_timer #(.CYCLES(BUSY_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (launch),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    smem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .page_we_i    (launch && (pend_q == OP_WRITE)),
        .page_base_i  (base_q),
        .page_mask_i  (pmask_q),
        .page_data_i  (pbuf_q),
        .erase_i      (launch && (pend_q == OP_ERASE)),
        .erase_addr_i (addr_q),
        .fill_i       (launch && ((pend_q == OP_CLEAR_ALL) || (pend_q == OP_FILL_ALL))),
        .fill_data_i  ((pend_q == OP_CLEAR_ALL) ? {DATA_W{1'b1}} : fill_q)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (sk_rise && di_s) st_d = ST_OPC;
            ST_OPC:      if (sk_rise && (bit_cnt == CNT_W'(1))) st_d = ST_ADDR;
            ST_ADDR: begin
                if (sk_rise && addr_last) begin
                    case (opc_q)
                        CODE_READ:  st_d = ST_READ;
                        CODE_WRITE: st_d = ST_WDATA;
                        CODE_ERASE: st_d = ST_HOLD;
                        default: begin
                            if (ext_sel == SUB_CLEAR)     st_d = ST_HOLD;
                            else if (ext_sel == SUB_FILL) st_d = ST_FILLDATA;
                            else                          st_d = ST_SKIP;
                        end
                    endcase
                end
            end
            ST_FILLDATA: if (sk_rise && data_last) st_d = ST_HOLD;
            ST_READ, ST_WDATA, ST_HOLD, ST_SKIP: st_d = st_q;
            ST_BUSY:     if (tmr_done) st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
        if ((st_q != ST_BUSY) && !cs_s) st_d = launch ? ST_BUSY : ST_IDLE;
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= OP_NONE;
            opc_q   <= '0;
            addr_q  <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
            do_q    <= 1'b0;
            wen_q   <= 1'b0;
            rdy_q   <= 1'b0;
            pbuf_q  <= '0;
            pmask_q <= '0;
            ptr_q   <= '0;
            base_q  <= '0;
            fill_q  <= '0;
        end else if ((st_q != ST_BUSY) && !cs_s) begin
            pend_q  <= OP_NONE;
            pmask_q <= '0;
            bit_cnt <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (sk_rise && di_s) begin
                        rdy_q   <= 1'b0;
                        bit_cnt <= '0;
                        pend_q  <= OP_NONE;
                        pmask_q <= '0;
                    end
                end
                ST_OPC: begin
                    if (sk_rise) begin
                        opc_q   <= {opc_q[0], di_s};
                        bit_cnt <= (bit_cnt == CNT_W'(1)) ? '0 : bit_cnt + 1'b1;
                    end
                end
                ST_ADDR: begin
                    if (sk_rise) begin
                        addr_q <= full_addr;
                        if (addr_last) begin
                            bit_cnt <= '0;
                            case (opc_q)
                                CODE_READ: begin
                                    shreg <= rd_data;
                                    do_q  <= 1'b0;
                                end
                                CODE_WRITE: begin
                                    ptr_q  <= full_addr[PAGE_W-1:0];
                                    base_q <= full_addr[ADDR_W-1:PAGE_W];
                                end
                                CODE_ERASE: pend_q <= OP_ERASE;
                                default: begin
                                    if (ext_sel == SUB_UNLOCK)     wen_q  <= 1'b1;
                                    else if (ext_sel == SUB_LOCK)  wen_q  <= 1'b0;
                                    else if (ext_sel == SUB_CLEAR) pend_q <= OP_CLEAR_ALL;
                                end
                            endcase
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (sk_rise) begin
                        if (bit_cnt == CNT_W'(DATA_W)) begin
                            addr_q  <= addr_q + 1'b1;
                            do_q    <= rd_data[DATA_W-1];
                            shreg   <= {rd_data[DATA_W-2:0], 1'b0};
                            bit_cnt <= CNT_W'(1);
                        end else begin
                            do_q    <= shreg[DATA_W-1];
                            shreg   <= {shreg[DATA_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    if (sk_rise) begin
                        shreg <= next_byte;
                        if (data_last) begin
                            pbuf_q[ptr_q]  <= next_byte;
                            pmask_q[ptr_q] <= 1'b1;
                            ptr_q          <= ptr_q + 1'b1;
                            pend_q         <= OP_WRITE;
                            bit_cnt        <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_FILLDATA: begin
                    if (sk_rise) begin
                        shreg <= next_byte;
                        if (data_last) begin
                            fill_q  <= next_byte;
                            pend_q  <= OP_FILL_ALL;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_BUSY: begin
                    pend_q  <= OP_NONE;
                    pmask_q <= '0;
                    if (tmr_done) rdy_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        do_oe_o = 1'b0;
        do_o    = 1'b0;
        if (cs_s) begin
            unique case (st_q)
                ST_READ: begin
                    do_oe_o = 1'b1;
                    do_o    = do_q;
                end
                ST_BUSY: begin
                    do_oe_o = 1'b1;
                    do_o    = 1'b0;
                end
                ST_IDLE: begin
                    do_oe_o = rdy_q;
                    do_o    = rdy_q;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smem_checker.sv
module smem_checker
    import smem_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cs_s,
    input logic        do_o,
    input logic        do_oe_o,
    input logic        busy,
    input logic        wen,
    input logic        rdy,
    input smem_state_e st
);

    a_r12_released_when_deselected: assert property (
        @(posedge clk) disable iff (!rst_n)
        !cs_s |-> !do_oe_o
    );

    a_r9_busy_reports_low: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && cs_s) |-> (do_oe_o && !do_o)
    );

    a_r5_launch_needs_unlock: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen)
    );

    a_r10_ready_after_busy: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rdy
    );

    a_r11_lock_frozen_while_busy: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wen)
    );

    a_r3_dummy_zero_first: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st == ST_READ && $past(st) == ST_ADDR && cs_s) |-> (do_oe_o && !do_o)
    );

endmodule

bind serial_mem_slave smem_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .do_o    (do_o),
    .do_oe_o (do_oe_o),
    .busy    (tmr_busy),
    .wen     (wen_q),
    .rdy     (rdy_q),
    .st      (st_q)
);

// File: tb/serial_mem_slave_bench.sv
`timescale 1ns/1ps
module serial_mem_slave_bench;

    localparam int BUSY = 400;
    localparam int WD   = 150000;

    // {1'b0, addr[6:0], data[7:0]}
    localparam logic [15:0] VEC [8] = '{
        16'h00A5, 16'h7F5A, 16'h010F, 16'h40F0,
        16'h1500, 16'h6B81, 16'h3E7E, 16'h52C3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_oe;
    int   n_checks = 0;
    int   n_fail = 0;

    always #2.5 clk = ~clk;

    serial_mem_slave #(.BUSY_CYC(BUSY)) u_serial_mem_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs),
        .sk_i    (sk),
        .di_i    (di),
        .do_o    (do_o),
        .do_oe_o (do_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_pin(input logic oe, input logic d, input string req);
        check((do_oe === oe) && (!oe || do_o === d), req, {14'b0, do_oe, do_o}, {14'b0, oe, d});
    endtask

    task automatic sk_bit(input logic b);
        di = b;
        tick(6);
        sk = 1'b1;
        tick(6);
        sk = 1'b0;
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [6:0] a);
        sk_bit(1'b1);
        for (int i = 1; i >= 0; i--) sk_bit(op[i]);
        for (int i = 6; i >= 0; i--) sk_bit(a[i]);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) sk_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            sk_bit(1'b0);
            v = {v[6:0], do_o};
        end
    endtask

    task automatic deselect();
        cs = 1'b0;
        tick(6);
    endtask

    task automatic read_expect(input logic [6:0] a, input logic [7:0] e0, input bit two,
                               input logic [7:0] e1, input string req);
        logic [7:0] v;
        cs = 1'b1;
        tick(4);
        send_hdr(2'b10, a);
        check_pin(1'b1, 1'b0, "R3 dummy zero");
        get_byte(v);
        check(v === e0, req, {8'b0, v}, {8'b0, e0});
        if (two) begin
            get_byte(v);
            check(v === e1, req, {8'b0, v}, {8'b0, e1});
        end
        deselect();
    endtask

    task automatic ext_cmd(input logic [1:0] sub);
        cs = 1'b1;
        tick(4);
        send_hdr(2'b00, {sub, 5'b0});
        deselect();
    endtask

    task automatic wait_prog();
        tick(BUSY + 20);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state, output released
        check_pin(1'b0, 1'b0, "R1 released after reset");
        cs = 1'b1;
        tick(6);
        check_pin(1'b0, 1'b0, "R1 selected, no status");
        cs = 1'b0;
        tick(6);
        read_expect(7'h05, 8'hFF, 1'b0, 8'h00, "R1 erased after reset");

        // R5: write while locked is ignored
        cs = 1'b1;
        tick(4);
        send_hdr(2'b01, 7'h03);
        send_byte(8'h12);
        deselect();
        cs = 1'b1;
        tick(8);
        check_pin(1'b0, 1'b0, "R5 no busy when locked");
        deselect();
        wait_prog();
        read_expect(7'h03, 8'hFF, 1'b0, 8'h00, "R5 locked write ignored");

        // R5 unlock, then table walk: R6 single byte writes, R3 reads
        ext_cmd(2'b11);
        for (int k = 0; k < 8; k++) begin
            cs = 1'b1;
            tick(4);
            send_hdr(2'b01, VEC[k][14:8]);
            send_byte(VEC[k][7:0]);
            deselect();
            wait_prog();
            read_expect(VEC[k][14:8], VEC[k][7:0], 1'b0, 8'h00, "R3 R6 table readback");
        end

        // R2: leading zeros before the start bit are skipped
        cs = 1'b1;
        tick(4);
        sk_bit(1'b0);
        sk_bit(1'b0);
        sk_bit(1'b0);
        send_hdr(2'b10, 7'h40);
        check_pin(1'b1, 1'b0, "R2 dummy after leading zeros");
        get_byte(v);
        check(v === 8'hF0, "R2 leading zeros", {8'b0, v}, 16'h00F0);
        deselect();

        // R4: stream across the top address
        read_expect(7'h7F, 8'h5A, 1'b1, 8'hA5, "R4 wrap 127 to 0");
        read_expect(7'h00, 8'hA5, 1'b1, 8'h0F, "R4 stream next address");

        // R6: page write wraps inside page, trailing partial byte dropped
        cs = 1'b1;
        tick(4);
        send_hdr(2'b01, 7'h2E);
        send_byte(8'hA1);
        send_byte(8'hA2);
        send_byte(8'hA3);
        sk_bit(1'b0);
        sk_bit(1'b1);
        sk_bit(1'b1);
        cs = 1'b0;
        tick(4);
        // R9: busy shown while selected
        cs = 1'b1;
        tick(6);
        check_pin(1'b1, 1'b0, "R9 busy low");
        // R11: unlock-off frame during busy is ignored
        send_hdr(2'b00, 7'h00);
        check_pin(1'b1, 1'b0, "R9 still busy");
        tick(BUSY);
        check_pin(1'b1, 1'b1, "R10 ready high");
        cs = 1'b0;
        tick(6);
        check_pin(1'b0, 1'b0, "R12 released when deselected");
        cs = 1'b1;
        tick(6);
        check_pin(1'b1, 1'b1, "R10 ready persists");
        sk_bit(1'b1);
        tick(2);
        check_pin(1'b0, 1'b0, "R10 cleared by start bit");
        deselect();
        read_expect(7'h2E, 8'hA1, 1'b1, 8'hA2, "R6 page bytes");
        read_expect(7'h20, 8'hA3, 1'b1, 8'hFF, "R6 page wrap, partial dropped");
        read_expect(7'h30, 8'hFF, 1'b0, 8'h00, "R6 next page untouched");

        // R11: lock frame was ignored, so a write still works
        cs = 1'b1;
        tick(4);
        send_hdr(2'b01, 7'h33);
        send_byte(8'h5C);
        deselect();
        wait_prog();
        read_expect(7'h33, 8'h5C, 1'b0, 8'h00, "R11 busy frame ignored");

        // R7: single erase
        cs = 1'b1;
        tick(4);
        send_hdr(2'b11, 7'h33);
        deselect();
        wait_prog();
        read_expect(7'h33, 8'hFF, 1'b0, 8'h00, "R7 erase");
        read_expect(7'h2E, 8'hA1, 1'b0, 8'h00, "R7 neighbour kept");

        // R8: fill-all
        cs = 1'b1;
        tick(4);
        send_hdr(2'b00, 7'h20);
        send_byte(8'h3C);
        deselect();
        wait_prog();
        read_expect(7'h00, 8'h3C, 1'b0, 8'h00, "R8 fill-all low");
        read_expect(7'h7F, 8'h3C, 1'b0, 8'h00, "R8 fill-all high");

        // R5: lock, then erase is ignored but reads work
        ext_cmd(2'b00);
        cs = 1'b1;
        tick(4);
        send_hdr(2'b11, 7'h00);
        deselect();
        cs = 1'b1;
        tick(8);
        check_pin(1'b0, 1'b0, "R5 locked erase no busy");
        deselect();
        wait_prog();
        read_expect(7'h00, 8'h3C, 1'b0, 8'h00, "R5 locked erase ignored");

        // R8: clear-all after unlocking
        ext_cmd(2'b11);
        ext_cmd(2'b10);
        wait_prog();
        read_expect(7'h55, 8'hFF, 1'b0, 8'h00, "R8 clear-all");

        // R12: aborted write stores nothing
        cs = 1'b1;
        tick(4);
        send_hdr(2'b01, 7'h10);
        sk_bit(1'b0);
        sk_bit(1'b1);
        sk_bit(1'b0);
        sk_bit(1'b0);
        deselect();
        cs = 1'b1;
        tick(8);
        check_pin(1'b0, 1'b0, "R12 abort no busy");
        deselect();
        wait_prog();
        read_expect(7'h10, 8'hFF, 1'b0, 8'h00, "R12 aborted write");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule